// File: doc/BRIEF.md
# Real-Time-Clock Prescaler with Selectable Frequency and Timer Sources

This block divides a low-rate crystal reference down to the rates a real-time clock needs. The reference arrives as a clock enable, `ref_en`, on a faster system clock. Each enable marks one half-period edge of the 32768 Hz reference, so enables come at 65536 per second. A free-running binary counter advances once per enable. Counter stage k is then a 50% duty square wave at 32768/2^k Hz.

Two results are taken from the counter.

- **Frequency output.** A registered square wave whose rate is chosen by a 2-bit output-select port. Both the lowest and the highest code give the full reference rate.
- **Timer source tick.** A one-cycle pulse that feeds an external fixed-cycle countdown timer. A 2-bit timer-select port chooses it from one of four sources:
  - the rising edge of a divider stage, at 4096 Hz or 64 Hz;
  - the rising edge of the second-update input;
  - the rising edge of the minute-update input.

Top module: `rtc_prescaler`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `freq_out` and `tmr_tick` are 0, and the divider count is 0.
- R2: The divider count increments by one on each clock edge where `ref_en` is 1. It wraps after 65536 enables and is never cleared by a change of either select port.
- R3: With `out_sel` = 2'b00, `freq_out` follows divider stage 0 (32768 Hz) and toggles on every enable.
- R4: With `out_sel` = 2'b01, `freq_out` follows divider stage 5 (1024 Hz) and toggles every 32 enables.
- R5: With `out_sel` = 2'b10, `freq_out` follows divider stage 15 (1 Hz) and toggles every 32768 enables.
- R6: With `out_sel` = 2'b11, `freq_out` behaves exactly as with 2'b00.
- R7: `freq_out` changes only in the cycle after an enable edge. A change of `out_sel` while `ref_en` is 0 leaves `freq_out` unchanged until the next enable.
- R8: With `tmr_sel` = 2'b00, `tmr_tick` pulses in the cycle after each enable that takes divider stage 3 from 0 to 1. That is one pulse per 16 enables (4096 Hz).
- R9: With `tmr_sel` = 2'b01, `tmr_tick` pulses in the cycle after each enable that takes divider stage 9 from 0 to 1. That is one pulse per 1024 enables (64 Hz).
- R10: With `tmr_sel` = 2'b10, `tmr_tick` pulses in the cycle after each 0-to-1 transition of `sec_upd`. A level held high gives a single pulse.
- R11: With `tmr_sel` = 2'b11, `tmr_tick` pulses in the cycle after each 0-to-1 transition of `min_upd`.
- R12: Each `tmr_tick` pulse lasts exactly one cycle. Sources that `tmr_sel` does not choose cause no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference half-period enable (65536 per second) |
| sec_upd | input | 1 | Second-update pulse from the timekeeping counter |
| min_upd | input | 1 | Minute-update pulse from the timekeeping counter |
| out_sel | input | 2 | Frequency output rate select |
| tmr_sel | input | 2 | Timer source tick select |
| freq_out | output | 1 | Selected square-wave output |
| tmr_tick | output | 1 | One-cycle timer source tick |

## Verification
The bench drives gapped and continuous enables. It checks that the code 2'b11 aliases full rate rather than some slower stage; a wrong decode would show a slow or stuck output. It changes `out_sel` while enables are held off; a combinational select would glitch `freq_out` at once. It holds `sec_upd` high for several cycles and pulses the unselected minute input. A level-sensitive or unmasked source would give repeated or stray ticks. It measures tick spacing and the 1 Hz half-period, which catches a wrong stage tap or a divider cleared on a select change.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;

    localparam int DIV_W     = 16;
    localparam int TAP_FULL  = 0;
    localparam int TAP_KHZ   = 5;
    localparam int TAP_HZ    = 15;
    localparam int TAP_TFAST = 3;
    localparam int TAP_TSLOW = 9;

    typedef enum logic [1:0] {
        OSEL_FULL_A = 2'b00,
        OSEL_KHZ    = 2'b01,
        OSEL_ONE_HZ = 2'b10,
        OSEL_FULL_B = 2'b11
    } out_sel_e;

    typedef enum logic [1:0] {
        TSEL_FAST = 2'b00,
        TSEL_SLOW = 2'b01,
        TSEL_SEC  = 2'b10,
        TSEL_MIN  = 2'b11
    } tmr_sel_e;

    typedef struct packed {
        logic full;
        logic khz;
        logic hz;
    } freq_taps_t;

    typedef struct packed {
        logic fast;
        logic slow;
    } div_edges_t;

    function automatic logic pick_freq(input out_sel_e sel, input freq_taps_t t);
        case (sel)
            OSEL_KHZ:    return t.khz;
            OSEL_ONE_HZ: return t.hz;
            default:     return t.full;
        endcase
    endfunction

endpackage

// File: rtl/rtcp_divider.sv
module rtcp_divider
    import rtcp_pkg::*;
#(
    parameter int W       = DIV_W,
    parameter int T_FULL  = TAP_FULL,
    parameter int T_KHZ   = TAP_KHZ,
    parameter int T_HZ    = TAP_HZ,
    parameter int T_FAST  = TAP_TFAST,
    parameter int T_SLOW  = TAP_TSLOW
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    output freq_taps_t taps_nxt,
    output div_edges_t edges
);
    localparam int NEDGE = 2;
    localparam int EDGE_TAP [NEDGE] = '{T_FAST, T_SLOW};

    logic [W-1:0]     cnt_q;
    logic [W-1:0]     cnt_d;
    logic [NEDGE-1:0] rise;

    assign cnt_d = adv ? cnt_q + W'(1) : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    for (genvar g = 0; g < NEDGE; g++) begin : g_edge
        assign rise[g] = adv & cnt_d[EDGE_TAP[g]] & ~cnt_q[EDGE_TAP[g]];
    end

    assign taps_nxt = '{full: cnt_d[T_FULL], khz: cnt_d[T_KHZ], hz: cnt_d[T_HZ]};
    assign edges    = '{fast: rise[0], slow: rise[1]};
endmodule

// File: rtl/rtcp_freq_mux.sv
module rtcp_freq_mux
    import rtcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  out_sel_e   sel,
    input  freq_taps_t taps_nxt,
    output logic       freq_q
);
    // The output register loads only with the divider, so a select change waits for the next edge.
    always_ff @(posedge clk) begin
        if (rst)      freq_q <= 1'b0;
        else if (adv) freq_q <= pick_freq(sel, taps_nxt);
    end
endmodule

// File: rtl/rtcp_tick_sel.sv
module rtcp_tick_sel
    import rtcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tmr_sel_e   sel,
    input  div_edges_t edges,
    input  logic       sec_upd,
    input  logic       min_upd,
    output logic       tick_q
);
    logic sec_prev, min_prev;
    logic sec_rise, min_rise;
    logic pick;

    assign sec_rise = sec_upd & ~sec_prev;
    assign min_rise = min_upd & ~min_prev;

    always_comb begin
        case (sel)
            TSEL_FAST: pick = edges.fast;
            TSEL_SLOW: pick = edges.slow;
            TSEL_SEC:  pick = sec_rise;
            default:   pick = min_rise;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_prev <= 1'b0;
            min_prev <= 1'b0;
            tick_q   <= 1'b0;
        end else begin
            sec_prev <= sec_upd;
            min_prev <= min_upd;
            tick_q   <= pick;
        end
    end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtcp_pkg::*;
#(
    parameter int W      = DIV_W,
    parameter int T_FULL = TAP_FULL,
    parameter int T_KHZ  = TAP_KHZ,
    parameter int T_HZ   = TAP_HZ,
    parameter int T_FAST = TAP_TFAST,
    parameter int T_SLOW = TAP_TSLOW
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_en,
    input  logic       sec_upd,
    input  logic       min_upd,
    input  logic [1:0] out_sel,
    input  logic [1:0] tmr_sel,
    output logic       freq_out,
    output logic       tmr_tick
);
    freq_taps_t taps_nxt;
    div_edges_t edges;

    rtcp_divider #(
        .W(W), .T_FULL(T_FULL), .T_KHZ(T_KHZ), .T_HZ(T_HZ),
        .T_FAST(T_FAST), .T_SLOW(T_SLOW)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .adv      (ref_en),
        .taps_nxt (taps_nxt),
        .edges    (edges)
    );

    rtcp_freq_mux u_fmux (
        .clk      (clk),
        .rst      (rst),
        .adv      (ref_en),
        .sel      (out_sel_e'(out_sel)),
        .taps_nxt (taps_nxt),
        .freq_q   (freq_out)
    );

    rtcp_tick_sel u_tsel (
        .clk     (clk),
        .rst     (rst),
        .sel     (tmr_sel_e'(tmr_sel)),
        .edges   (edges),
        .sec_upd (sec_upd),
        .min_upd (min_upd),
        .tick_q  (tmr_tick)
    );
endmodule

// File: rtl/rtcp_checker.sv
module rtcp_checker (
    input logic       clk,
    input logic       rst,
    input logic       ref_en,
    input logic       sec_upd,
    input logic       min_upd,
    input logic [1:0] out_sel,
    input logic [1:0] tmr_sel,
    input logic       freq_out,
    input logic       tmr_tick
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!freq_out && !tmr_tick)); // R1

    AST_FULL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (ref_en && out_sel[0] == out_sel[1] && $past(ref_en && out_sel[0] == out_sel[1]))
        |=> freq_out != $past(freq_out)); // R3

    AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ref_en |=> $stable(freq_out)); // R7

    AST_DIV_TICK_ON_EN: assert property (@(posedge clk) disable iff (rst)
        (tmr_tick && !$past(tmr_sel[1])) |-> $past(ref_en)); // R8

    AST_SEC_TICK: assert property (@(posedge clk) disable iff (rst)
        ($rose(sec_upd) && tmr_sel == 2'b10) |=> tmr_tick); // R10

    AST_MIN_TICK: assert property (@(posedge clk) disable iff (rst)
        ($rose(min_upd) && tmr_sel == 2'b11) |=> tmr_tick); // R11

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (tmr_tick && $stable(tmr_sel)) |=> (!tmr_tick || !$stable(tmr_sel))); // R12
endmodule

bind rtc_prescaler rtcp_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_en   (ref_en),
    .sec_upd  (sec_upd),
    .min_upd  (min_upd),
    .out_sel  (out_sel),
    .tmr_sel  (tmr_sel),
    .freq_out (freq_out),
    .tmr_tick (tmr_tick)
);

// File: tb/tb_rtc_prescaler.sv
module tb_rtc_prescaler;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b0;
    logic       sec_upd = 1'b0;
    logic       min_upd = 1'b0;
    logic [1:0] out_sel = 2'b00;
    logic [1:0] tmr_sel = 2'b00;
    logic       freq_out;
    logic       tmr_tick;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtc_prescaler dut (
        .clk(clk), .rst(rst), .ref_en(ref_en), .sec_upd(sec_upd), .min_upd(min_upd),
        .out_sel(out_sel), .tmr_sel(tmr_sel), .freq_out(freq_out), .tmr_tick(tmr_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on each rising edge.
    int    m_cnt;
    bit    m_freq, m_tick, m_ps, m_pm;
    string m_ftag = "R1", m_ttag = "R1";

    function automatic bit bit_of(input int v, input int k);
        return ((v >> k) & 1) != 0;
    endfunction

    always @(posedge clk) begin : model
        int nxt;
        int stage;
        if (rst) begin
            m_cnt = 0; m_freq = 0; m_tick = 0; m_ps = 0; m_pm = 0;
            m_ftag = "R1"; m_ttag = "R1";
        end else begin
            nxt = ref_en ? (m_cnt + 1) % 65536 : m_cnt;
            case (out_sel)
                2'b01:   begin stage = 5;  m_ftag = "R4"; end
                2'b10:   begin stage = 15; m_ftag = "R5"; end
                2'b11:   begin stage = 0;  m_ftag = "R6"; end
                default: begin stage = 0;  m_ftag = "R3"; end
            endcase
            if (!ref_en) m_ftag = "R7";
            if (ref_en) m_freq = bit_of(nxt, stage);
            case (tmr_sel)
                2'b00: begin m_tick = ref_en && bit_of(nxt, 3) && !bit_of(m_cnt, 3); m_ttag = "R8"; end
                2'b01: begin m_tick = ref_en && bit_of(nxt, 9) && !bit_of(m_cnt, 9); m_ttag = "R9"; end
                2'b10: begin m_tick = sec_upd && !m_ps; m_ttag = "R10"; end
                default: begin m_tick = min_upd && !m_pm; m_ttag = "R11"; end
            endcase
            m_ps  = sec_upd;
            m_pm  = min_upd;
            m_cnt = nxt;
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            check(freq_out == m_freq, m_ftag, freq_out, m_freq);
            check(tmr_tick == m_tick, m_ttag, tmr_tick, m_tick);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : stim
        int gap;
        int cnt;
        bit last;
        cycles(4);
        check(freq_out == 0 && tmr_tick == 0, "R1", {freq_out, tmr_tick}, 0);
        rst = 0;
        @(negedge clk);
        check(freq_out == 0 && tmr_tick == 0, "R1", {freq_out, tmr_tick}, 0);

        // Full-rate output, 4096 Hz timer tick, continuous enables
        ref_en = 1; out_sel = 2'b00; tmr_sel = 2'b00;
        cycles(40);
        while (!tmr_tick) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!tmr_tick && gap < 100);
        check(gap == 16, "R8", gap, 16);
        cycles(200);

        // 1024 Hz output, 64 Hz tick, gapped enables
        out_sel = 2'b01; tmr_sel = 2'b01;
        for (int i = 0; i < 4000; i++) begin
            ref_en = $urandom_range(0, 1) != 0;
            @(negedge clk);
        end

        // 64 Hz tick spacing with continuous enables
        ref_en = 1;
        while (!tmr_tick) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!tmr_tick && gap < 2000);
        check(gap == 1024, "R9", gap, 1024);

        // 1 Hz output: half-period of 32768 enables
        out_sel = 2'b10;
        cycles(3);
        last = freq_out;
        while (freq_out == last) @(negedge clk);
        last = freq_out; gap = 0;
        do begin @(negedge clk); gap++; end while (freq_out == last && gap < 40000);
        check(gap == 32768, "R5", gap, 32768);
        check(gap == 32768, "R2", gap, 32768);

        // Alias code for full rate
        out_sel = 2'b11;
        cycles(2);
        last = freq_out; @(negedge clk);
        check(freq_out != last, "R6", freq_out, !last);

        // Second source: single pulse, held level, unselected minute input
        tmr_sel = 2'b10;
        cycles(2);
        sec_upd = 1; @(negedge clk); sec_upd = 0;
        cycles(3);
        cnt = 0; sec_upd = 1;
        for (int i = 0; i < 8; i++) begin @(negedge clk); cnt += tmr_tick; end
        sec_upd = 0;
        check(cnt == 1, "R10", cnt, 1);
        cnt = 0; min_upd = 1;
        for (int i = 0; i < 4; i++) begin @(negedge clk); min_upd = 0; cnt += tmr_tick; end
        check(cnt == 0, "R12", cnt, 0);

        // Minute source, unselected second input
        tmr_sel = 2'b11;
        cycles(2);
        cnt = 0; min_upd = 1;
        for (int i = 0; i < 6; i++) begin @(negedge clk); cnt += tmr_tick; end
        min_upd = 0;
        check(cnt == 1, "R11", cnt, 1);
        cnt = 0; sec_upd = 1;
        for (int i = 0; i < 4; i++) begin @(negedge clk); sec_upd = 0; cnt += tmr_tick; end
        check(cnt == 0, "R12", cnt, 0);

        // Select change with enables held off
        ref_en = 0; out_sel = 2'b00;
        @(negedge clk);
        last = freq_out;
        for (int i = 0; i < 8; i++) begin
            out_sel = 2'(i);
            @(negedge clk);
            check(freq_out == last, "R7", freq_out, last);
        end
        out_sel = 2'b01; ref_en = 1;
        cycles(100);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        done = 1;
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule